// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block walks a table of 8-byte region descriptors held in memory and hands a disk-side data mover a series of (address, length) segments that together cover a requested number of bytes. Each descriptor names a buffer start address and a size word. The size word carries an even byte count, where zero stands for 64 KiB, and a flag that marks the final entry of the table. The walker fetches descriptors one at a time through a simple read request/response port. It splits the current buffer against the bytes the data side still wants, and it keeps any unused part of a buffer for the next request.

Software points the walker at a table with a start pulse while the walker is idle. The data side then issues byte-count requests. For each request the walker either emits segments until the count is used up and then pulses `done`, or pulses `exhausted` when the table runs out first. The table runs out when the final descriptor has been used up, or when the fetch pointer has moved one 4 KiB page past the base. The page limit guards against a table that never sets its final flag.

Top module: `sg_walker`

## Requirements
- R1: A descriptor response carries the buffer address word in `rd_data[31:0]` and the size/flags word in `rd_data[63:32]`.
- R2: The segment length is bits 15:0 of the size word with bit 0 cleared. Bits 30:16 of the size word have no effect.
- R3: A masked length of zero gives a segment of 65536 bytes.
- R4: Bit 31 of the size word (`rd_data[63]`) marks the final descriptor. Once that segment is used up, no further fetch is made and a request that is still unsatisfied ends with `exhausted`.
- R5: Fetches go to the table base with bits 1:0 cleared, then step by 8 bytes per fetch. A fetch is made only when the current segment has no bytes left.
- R6: No fetch is issued once the pointer is 4096 or more bytes past the base. A request still open at that point ends with `exhausted`, so at most 512 descriptors are read per table.
- R7: Each segment length is the smaller of the bytes still requested and the bytes left in the current buffer. `seg_last` is high on the segment that completes the request, and `done` pulses the cycle after it. Bytes left over in a buffer start the next request.
- R8: A request that is not satisfied never reports `done`. It reports `exhausted` exactly once, and `done` and `exhausted` are never high together.
- R9: A start pulse in the idle state reloads the pointer from the base and clears the current segment address, length and final flag. A start pulse while busy has no effect.
- R10: At most one fetch is outstanding at a time. No segment is presented between a fetch request and its response.
- R11: A zero-byte request reports `done` with no segment and no fetch.
- R12: The fetched buffer address is used unchanged, including unaligned low bits. Segment addresses within a buffer advance by the preceding chunk lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the table base and clear the walk state (honoured when idle) |
| tbl_base | input | 32 | Byte address of the descriptor table |
| rd_req | output | 1 | One-cycle descriptor fetch request |
| rd_addr | output | 32 | Fetch address |
| rd_vld | input | 1 | Fetch response valid |
| rd_data | input | 64 | Fetched descriptor, address word low |
| xfer_req | input | 1 | Byte-count request from the data side (honoured when idle) |
| xfer_bytes | input | 20 | Requested byte count |
| seg_vld | output | 1 | Segment valid, one cycle per segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 17 | Segment length in bytes |
| seg_last | output | 1 | This segment completes the request |
| done | output | 1 | Request satisfied |
| exhausted | output | 1 | Table ended before the request was satisfied |
| busy | output | 1 | Walker is handling a request |

## Verification
The assertions check on every cycle that segments are non-empty and never exceed the open request, and that no fetch crosses the page limit. They also check that the pointer steps by 8 on every response, that only one fetch is outstanding, and that a completing segment is followed by `done`. Only the bench scenarios can show that the decoded lengths, the zero-means-64 KiB rule, the unaligned buffer addresses and the carry-over of leftover bytes across requests match an independent model of the table. The same holds for the runaway table stopping after exactly 512 fetches and for a restart picking up a new, masked base.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [1:0] {
    SGW_IDLE = 2'd0,
    SGW_SCAN = 2'd1,
    SGW_WAIT = 2'd2
  } sgw_state_e;

  localparam int unsigned SGW_DESC_BYTES = 8;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [63:0]       desc,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [CNT_W:0]    buf_len,
  output logic              is_final
);
  logic [CNT_W-1:0] raw_cnt;

  always_comb begin
    buf_addr = desc[ADDR_W-1:0];
    raw_cnt  = desc[32 +: CNT_W] & ~{{(CNT_W-1){1'b0}}, 1'b1};
    if (raw_cnt == '0) begin
      buf_len = {1'b1, {CNT_W{1'b0}}};
    end else begin
      buf_len = {1'b0, raw_cnt};
    end
    is_final = desc[63];
  end
endmodule

// File: rtl/sgw_chunk.sv
module sgw_chunk #(
  parameter int unsigned REQ_W = 20,
  parameter int unsigned LEN_W = 17
) (
  input  logic [REQ_W-1:0] rem_bytes,
  input  logic [LEN_W-1:0] seg_left,
  output logic [LEN_W-1:0] chunk,
  output logic             ends_req
);
  logic [REQ_W-1:0] seg_ext;

  always_comb begin
    seg_ext = REQ_W'(seg_left);
    if (rem_bytes <= seg_ext) begin
      chunk    = LEN_W'(rem_bytes);
      ends_req = 1'b1;
    end else begin
      chunk    = seg_left;
      ends_req = 1'b0;
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REQ_W      = 20,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_vld,
  input  logic [63:0]       rd_data,
  input  logic              xfer_req,
  input  logic [REQ_W-1:0]  xfer_bytes,
  output logic              seg_vld,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [CNT_W:0]    seg_len,
  output logic              seg_last,
  output logic              done,
  output logic              exhausted,
  output logic              busy
);
  localparam int unsigned LEN_W = CNT_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] PAGE_LIM   = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] DESC_STEP  = ADDR_W'(SGW_DESC_BYTES);

  sgw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] caddr_q, caddr_d;
  logic [LEN_W-1:0]  clen_q, clen_d;
  logic              clast_q, clast_d;
  logic [REQ_W-1:0]  rem_q, rem_d;

  logic [ADDR_W-1:0] dec_addr;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_final;
  logic [LEN_W-1:0]  chunk;
  logic              ends_req;
  logic              page_out;

  sgw_desc_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
    .desc     (rd_data),
    .buf_addr (dec_addr),
    .buf_len  (dec_len),
    .is_final (dec_final)
  );

  sgw_chunk #(.REQ_W(REQ_W), .LEN_W(LEN_W)) u_chunk (
    .rem_bytes (rem_q),
    .seg_left  (clen_q),
    .chunk     (chunk),
    .ends_req  (ends_req)
  );

  assign page_out = (ptr_q - base_q) >= PAGE_LIM;

  always_comb begin
    state_d   = state_q;
    base_d    = base_q;
    ptr_d     = ptr_q;
    caddr_d   = caddr_q;
    clen_d    = clen_q;
    clast_d   = clast_q;
    rem_d     = rem_q;
    rd_req    = 1'b0;
    seg_vld   = 1'b0;
    done      = 1'b0;
    exhausted = 1'b0;
    unique case (state_q)
      SGW_IDLE: begin
        if (start) begin
          base_d  = tbl_base & ALIGN_MASK;
          ptr_d   = tbl_base & ALIGN_MASK;
          caddr_d = '0;
          clen_d  = '0;
          clast_d = 1'b0;
        end else if (xfer_req) begin
          rem_d   = xfer_bytes;
          state_d = SGW_SCAN;
        end
      end
      SGW_SCAN: begin
        if (rem_q == '0) begin
          done    = 1'b1;
          state_d = SGW_IDLE;
        end else if (clen_q == '0) begin
          if (clast_q || page_out) begin
            exhausted = 1'b1;
            state_d   = SGW_IDLE;
          end else begin
            rd_req  = 1'b1;
            state_d = SGW_WAIT;
          end
        end else begin
          seg_vld = 1'b1;
          caddr_d = caddr_q + ADDR_W'(chunk);
          clen_d  = clen_q - chunk;
          rem_d   = rem_q - REQ_W'(chunk);
        end
      end
      SGW_WAIT: begin
        if (rd_vld) begin
          caddr_d = dec_addr;
          clen_d  = dec_len;
          clast_d = dec_final;
          ptr_d   = ptr_q + DESC_STEP;
          state_d = SGW_SCAN;
        end
      end
      default: state_d = SGW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SGW_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      caddr_q <= '0;
      clen_q  <= '0;
      clast_q <= 1'b0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      caddr_q <= caddr_d;
      clen_q  <= clen_d;
      clast_q <= clast_d;
      rem_q   <= rem_d;
    end
  end

  assign rd_addr  = ptr_q;
  assign seg_addr = caddr_q;
  assign seg_len  = chunk;
  assign seg_last = seg_vld & ends_req;
  assign busy     = (state_q != SGW_IDLE);

  AST_SEG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    seg_vld |-> (seg_len != '0) && (REQ_W'(seg_len) <= rem_q)) else $error("seg size"); // R7
  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_last |=> done) else $error("done after last"); // R7
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exhausted)) else $error("done and exhausted"); // R8
  AST_EXHAUST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> (clen_q == '0) && (rem_q != '0)) else $error("early exhaust"); // R8
  AST_PAGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((rd_addr - base_q) < PAGE_LIM)) else $error("page crossed"); // R6
  AST_FETCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (clen_q == '0) && !clast_q) else $error("fetch with data left"); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && state_q == SGW_WAIT) |=> (ptr_q == $past(ptr_q) + DESC_STEP)) else $error("ptr step"); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req && !seg_vld) else $error("second fetch"); // R10
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (clen_q == '0) && !clast_q &&
      (ptr_q == ($past(tbl_base) & ALIGN_MASK))) else $error("start reload"); // R9
endmodule

// File: tb/sg_walker_bench.sv
`timescale 1ns/1ps
module sg_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_vld = 1'b0;
  logic [63:0] rd_data = '0;
  logic        xfer_req = 1'b0;
  logic [19:0] xfer_bytes = '0;
  logic        seg_vld;
  logic [31:0] seg_addr;
  logic [16:0] seg_len;
  logic        seg_last;
  logic        done;
  logic        exhausted;
  logic        busy;

  always #4 clk = ~clk;

  sg_walker u_sg_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data),
    .xfer_req(xfer_req), .xfer_bytes(xfer_bytes), .seg_vld(seg_vld),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .done(done), .exhausted(exhausted), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  int mode = 0;
  int fetch_cnt = 0;
  longint b_base = 0;
  longint r_ptr, r_addr, r_len, r_rem;
  bit r_last;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] desc_of(input int m, input int idx);
    logic [31:0] a, s;
    a = 32'h1000_0000 + 32'(idx) * 32'h0002_0000 + ((idx % 2 == 1) ? 32'd3 : 32'd0);
    s = 32'h0000_0002;
    if (m == 0) begin
      case (idx)
        0: s = 32'h0000_0000;
        1: s = 32'h0000_0101;
        2: s = 32'h0000_0007;
        3: s = 32'h0000_FFFF;
        4: s = 32'h7ABC_00F0;
        default: s = 32'h8000_0010;
      endcase
    end else if (m == 2) begin
      a = 32'h2000_0005;
      s = 32'h8000_0040;
    end
    return {s, a};
  endfunction

  function automatic longint len_of(input logic [31:0] s);
    logic [15:0] c;
    c = s[15:0] & 16'hFFFE;
    return (c == 16'h0) ? 65536 : longint'(c);
  endfunction

  // memory responder, latency 2 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        int idx;
        chk(rd_addr == 32'(b_base + 8 * fetch_cnt), "R5 fetch address", rd_addr, b_base + 8 * fetch_cnt);
        idx = int'((longint'(rd_addr) - b_base) / 8);
        fetch_cnt++;
        repeat (2) @(negedge clk);
        rd_data = desc_of(mode, idx);
        rd_vld  = 1'b1;
        @(negedge clk);
        rd_vld  = 1'b0;
      end
    end
  end

  task automatic do_start(input logic [31:0] b, input int m);
    @(negedge clk);
    mode = m;
    start = 1'b1;
    tbl_base = b;
    @(negedge clk);
    start = 1'b0;
    b_base = longint'(b & 32'hFFFF_FFFC);
    r_ptr = b_base; r_addr = 0; r_len = 0; r_last = 1'b0;
    fetch_cnt = 0;
  endtask

  task automatic ref_load();
    logic [63:0] d;
    while (r_len == 0 && !r_last && (r_ptr - b_base) < 4096) begin
      d = desc_of(mode, int'((r_ptr - b_base) / 8));
      r_addr = longint'(d[31:0]);
      r_len  = len_of(d[63:32]);
      r_last = d[63];
      r_ptr += 8;
    end
  endtask

  task automatic run_req(input longint n, input string tag);
    int segs = 0;
    bit fin = 0;
    r_rem = n;
    @(negedge clk);
    xfer_req = 1'b1;
    xfer_bytes = 20'(n);
    @(negedge clk);
    xfer_req = 1'b0;
    for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
      if (seg_vld) begin
        longint ch;
        segs++;
        ref_load();
        chk(r_len != 0, {tag, " R4/R6 segment after table end"}, seg_len, 0);
        ch = (r_rem < r_len) ? r_rem : r_len;
        chk(seg_addr == 32'(r_addr), {tag, " R1/R12 seg_addr"}, seg_addr, r_addr);
        chk(seg_len == 17'(ch), {tag, " R2/R3/R7 seg_len"}, seg_len, ch);
        chk(seg_last == (ch == r_rem), {tag, " R7 seg_last"}, seg_last, ch == r_rem);
        r_addr += ch; r_len -= ch; r_rem -= ch;
      end
      if (done || exhausted) begin
        fin = 1;
        chk(done == (r_rem == 0), {tag, " R7/R8 outcome done"}, done, r_rem == 0);
        chk(exhausted == (r_rem != 0), {tag, " R8 outcome exhausted"}, exhausted, r_rem != 0);
        if (exhausted) begin
          ref_load();
          chk(r_len == 0 && (r_last || (r_ptr - b_base) >= 4096),
              {tag, " R4/R6 table really ended"}, r_len, 0);
        end
        chk(fetch_cnt == int'((r_ptr - b_base) / 8), {tag, " R5 fetch count"}, fetch_cnt, (r_ptr - b_base) / 8);
        if (n == 0) chk(segs == 0, {tag, " R11 no segment"}, segs, 0);
      end
      @(negedge clk);
    end
    chk(fin, {tag, " request never ended"}, fin, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req && !seg_vld && !done && !exhausted && !busy, "R9 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req, "R9 idle after reset", busy, 0);

    // table with varied sizes, masked bits, zero length, unaligned addresses
    do_start(32'h0000_4000, 0);
    run_req(0, "R11 zero request");
    chk(fetch_cnt == 0, "R11 no fetch", fetch_cnt, 0);
    run_req(100, "R3 part of 64KiB buffer");
    run_req(70000, "R7 spans buffers");
    run_req(7, "R2 odd request");
    run_req(1, "R7 single byte");
    run_req(61000, "R12 unaligned buffer");
    run_req(500, "R4 past final entry");

    // single final descriptor, exact fit then nothing left
    do_start(32'h0000_6000, 2);
    run_req(64, "R4 exact fit");
    run_req(1, "R4 after final");
    chk(fetch_cnt == 1, "R4 no fetch after final", fetch_cnt, 1);

    // start while busy is ignored: base change must not affect fetches
    do_start(32'h0000_6000, 1);
    fork
      run_req(2000, "R6 runaway table");
      begin
        repeat (40) @(negedge clk);
        start = 1'b1; tbl_base = 32'h0000_9000;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(fetch_cnt == 512, "R6 fetch limit", fetch_cnt, 512);

    // restart with unaligned base
    do_start(32'h0000_8003, 0);
    run_req(65536, "R9 restart masked base");
    chk(fetch_cnt == 1, "R9 one fetch after restart", fetch_cnt, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule